// File: doc/BRIEF.md
# GPIO Pin Sense Interrupt Unit

This unit watches the input pins of one port and turns pin activity into two port interrupts, one event line per pin and a wake request. Each pin selects its own sense mode (both edges, rising edge, falling edge, low level, or input disabled) and may have its input inverted. The unit therefore covers high-level sensing as well, by combining low-level sensing with inversion. Each pin's input passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier.

Two pin masks choose which pins feed interrupt 0 and interrupt 1. A detection on any selected pin sets a sticky flag. Software clears a flag by pulsing a one on its clear bit. Each interrupt has a 2-bit priority level, and level zero disables it. A combinational wake request is raised for conditions that can be seen with the clock stopped. The full-asynchronous pin (pin 2 by default) supports every sense mode for wake. The other pins support wake only in both-edge and low-level modes.

Top module: `gpio_sense_irq`

## Requirements
- R1: `pin_state_o[i]` equals `pin_i[i] ^ invert_i[i]`, delayed by two clock edges through the synchroniser, while pin i is not disabled.
- R2: Mode code 4, and any code from 5 to 7, disables pin i. A disabled pin reads 0 on `pin_state_o`, and it produces no event, no flag and no wake.
- R3: Mode codes: 0 = both edges, 1 = rising, 2 = falling, 3 = low level. An edge of the inverted pin value sets the selected flag on the third clock edge after the pin changes.
- R4: In low-level mode, a selected flag is set while the inverted pin value stays 0. It sets again on the same edge as a clear, for as long as the low level lasts.
- R5: `invert_i[i]` inverts the pin before sensing. A rising edge on `pin_i` is therefore sensed as a falling edge, and a high level is sensed as a low level.
- R6: In an edge mode, `event_o[i]` is a one-cycle pulse that is visible after the second clock edge following the pin change. In low-level mode, `event_o[i]` is the combinational value `~(pin_i[i] ^ invert_i[i])`.
- R7: `flag_o[k]` is set only by pins whose bit is 1 in the mask of interrupt k (`mask0_i` for k=0, `mask1_i` for k=1).
- R8: A flag stays set until `flag_clr_i[k]` is 1 on a clock edge. When a new detection arrives on the same edge as a clear, the set wins.
- R9: `irq_o[k]` is `flag_o[k]` when the priority of interrupt k is nonzero, and 0 otherwise. The priority output of interrupt k equals its priority input while `irq_o[k]` is 1, and reads 0 otherwise.
- R10: `wake_o` is raised at once, with no clock edge, when a pin that is masked into an interrupt with nonzero priority sees a wake-capable condition. Pin 2 supports modes 0 to 3 for wake. Every other pin supports only modes 0 and 3.
- R11: A low pulse in low-level mode that falls between two clock edges raises `wake_o` but does not set the flag.
- R12: After reset, the flags, the interrupt outputs, the priority outputs and `pin_state_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Raw pin levels |
| sense_mode_i | input | 3*NPIN | Sense mode per pin, 3 bits for each pin, pin 0 in the low bits |
| invert_i | input | NPIN | Input inversion per pin |
| mask0_i | input | NPIN | Pins that feed interrupt 0 |
| mask1_i | input | NPIN | Pins that feed interrupt 1 |
| prio0_i | input | 2 | Priority of interrupt 0 (0 = disabled) |
| prio1_i | input | 2 | Priority of interrupt 1 (0 = disabled) |
| flag_clr_i | input | 2 | Write-one clear strobe per flag |
| pin_state_o | output | NPIN | Synchronised, inverted pin value |
| event_o | output | NPIN | Per-pin event line |
| flag_o | output | 2 | Sticky interrupt flags |
| irq_o | output | 2 | Interrupt requests |
| irq0_prio_o | output | 2 | Level of a pending interrupt 0 |
| irq1_prio_o | output | 2 | Level of a pending interrupt 1 |
| wake_o | output | 1 | Combinational wake request |

## Verification
The assertions check, on every cycle, that flags hold until cleared and rise only when their mask is nonzero. They also check that priority outputs and wake appear only with a nonzero priority, and that a pin disabled for three cycles reads 0. The timing of the synchroniser and edge detector can only be shown by the bench's scenarios. These cover which mode and polarity fire on which transition, the combinational event and wake values, the set-over-clear collision and the sub-cycle low glitch. They sweep every pin through every mode and polarity.

// File: rtl/gpio_sense_irq.sv
module gpio_sense_irq #(
  parameter int NPIN = 8,
  parameter int ASYNC_PIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [3*NPIN-1:0] sense_mode_i,
  input  logic [NPIN-1:0]   invert_i,
  input  logic [NPIN-1:0]   mask0_i,
  input  logic [NPIN-1:0]   mask1_i,
  input  logic [1:0]        prio0_i,
  input  logic [1:0]        prio1_i,
  input  logic [1:0]        flag_clr_i,
  output logic [NPIN-1:0]   pin_state_o,
  output logic [NPIN-1:0]   event_o,
  output logic [1:0]        flag_o,
  output logic [1:0]        irq_o,
  output logic [1:0]        irq0_prio_o,
  output logic [1:0]        irq1_prio_o,
  output logic              wake_o
);

  localparam logic [2:0] M_BOTH = 3'd0;
  localparam logic [2:0] M_RISE = 3'd1;
  localparam logic [2:0] M_FALL = 3'd2;
  localparam logic [2:0] M_LOW  = 3'd3;

  logic [NPIN-1:0] raw, gated, sync1, sync2, prev;
  logic [NPIN-1:0] hit, wake_hit, on, wake_ok;

  assign raw = pin_i ^ invert_i;

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_pin
      logic [2:0] md;
      assign md = sense_mode_i[3*gi +: 3];
      assign on[gi] = (md <= M_LOW);
      assign gated[gi] = on[gi] & raw[gi];

      always_comb begin
        hit[gi] = 1'b0;
        wake_hit[gi] = 1'b0;
        case (md)
          M_BOTH: begin
            hit[gi] = sync2[gi] ^ prev[gi];
            wake_hit[gi] = raw[gi] ^ sync2[gi];
          end
          M_RISE: begin
            hit[gi] = sync2[gi] & ~prev[gi];
            wake_hit[gi] = raw[gi] & ~sync2[gi];
          end
          M_FALL: begin
            hit[gi] = ~sync2[gi] & prev[gi];
            wake_hit[gi] = ~raw[gi] & sync2[gi];
          end
          M_LOW: begin
            hit[gi] = ~sync2[gi];
            wake_hit[gi] = ~raw[gi];
          end
          default: ;
        endcase
      end

      if (gi == ASYNC_PIN) begin : g_full
        assign wake_ok[gi] = on[gi];
      end else begin : g_lim
        assign wake_ok[gi] = (md == M_BOTH) || (md == M_LOW);
      end

      assign event_o[gi] = (md == M_LOW) ? ~raw[gi] : hit[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= gated;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign pin_state_o = sync2;

  logic [1:0] set_now, prio_on;
  assign set_now = {|(hit & mask1_i), |(hit & mask0_i)};
  assign prio_on = {prio1_i != 2'd0, prio0_i != 2'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~flag_clr_i) | set_now;
  end

  assign irq_o       = flag_o & prio_on;
  assign irq0_prio_o = irq_o[0] ? prio0_i : 2'd0;
  assign irq1_prio_o = irq_o[1] ? prio1_i : 2'd0;

  logic [NPIN-1:0] wake_sel;
  assign wake_sel = (mask0_i & {NPIN{prio_on[0]}}) | (mask1_i & {NPIN{prio_on[1]}});
  assign wake_o   = |(wake_hit & wake_ok & wake_sel);

endmodule

// File: rtl/gpio_sense_irq_chk.sv
module gpio_sense_irq_chk #(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*NPIN-1:0] sense_mode_i,
  input logic [NPIN-1:0]   mask0_i,
  input logic [NPIN-1:0]   mask1_i,
  input logic [1:0]        prio0_i,
  input logic [1:0]        prio1_i,
  input logic [1:0]        flag_clr_i,
  input logic [NPIN-1:0]   pin_state_o,
  input logic [1:0]        flag_o,
  input logic [1:0]        irq_o,
  input logic [1:0]        irq0_prio_o,
  input logic [1:0]        irq1_prio_o,
  input logic              wake_o
);

  assert_flag0_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o[0] && !flag_clr_i[0] |=> flag_o[0]);
  assert_flag1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o[1] && !flag_clr_i[1] |=> flag_o[1]);

  assert_flag0_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[0]) |-> $past(mask0_i) != '0);
  assert_flag1_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[1]) |-> $past(mask1_i) != '0);

  assert_prio0_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_prio_o != 2'd0 |-> irq_o[0] && flag_o[0] && irq0_prio_o == prio0_i);
  assert_prio1_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_prio_o != 2'd0 |-> irq_o[1] && flag_o[1] && irq1_prio_o == prio1_i);

  assert_wake_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (prio0_i != 2'd0 && mask0_i != '0) || (prio1_i != 2'd0 && mask1_i != '0));

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_chk
      assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sense_mode_i[3*gi +: 3] > 3'd3 && $past(sense_mode_i[3*gi +: 3]) > 3'd3 &&
        $past(sense_mode_i[3*gi +: 3], 2) > 3'd3 |-> pin_state_o[gi] == 1'b0);
    end
  endgenerate

endmodule

bind gpio_sense_irq gpio_sense_irq_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .sense_mode_i(sense_mode_i),
  .mask0_i(mask0_i), .mask1_i(mask1_i), .prio0_i(prio0_i), .prio1_i(prio1_i),
  .flag_clr_i(flag_clr_i), .pin_state_o(pin_state_o), .flag_o(flag_o),
  .irq_o(irq_o), .irq0_prio_o(irq0_prio_o), .irq1_prio_o(irq1_prio_o),
  .wake_o(wake_o)
);

// File: tb/gpio_sense_irq_tb.sv
module gpio_sense_irq_tb_top;
  localparam int NPIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIN-1:0] pin = '0, inv = '0, m0 = '0, m1 = '0;
  logic [3*NPIN-1:0] mode = {NPIN{3'd4}};
  logic [1:0] p0 = '0, p1 = '0, clr = '0;
  logic [NPIN-1:0] st, ev;
  logic [1:0] flag, irq, ip0, ip1;
  logic wake;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_sense_irq #(.NPIN(NPIN), .ASYNC_PIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_mode_i(mode), .invert_i(inv),
    .mask0_i(m0), .mask1_i(m1), .prio0_i(p0), .prio1_i(p1), .flag_clr_i(clr),
    .pin_state_o(st), .event_o(ev), .flag_o(flag), .irq_o(irq),
    .irq0_prio_o(ip0), .irq1_prio_o(ip1), .wake_o(wake));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr = 2'b11;
    cyc(1);
    clr = 2'b00;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(2);
    check("R12 flags", flag, 0);
    check("R12 irq", irq, 0);
    check("R12 prio", {ip1, ip0}, 0);
    check("R12 state", st, 0);
    rst_n = 1'b1;
    cyc(1);

    // Sweep every pin, mode 0..4 and both polarities.
    for (int i = 0; i < NPIN; i++) begin
      for (int m = 0; m < 5; m++) begin
        for (int v = 0; v < 2; v++) begin
          mode = {NPIN{3'd4}};
          mode[3*i +: 3] = 3'(m);
          inv = '0; inv[i] = 1'(v);
          m0 = '0; m0[i] = 1'b1;
          m1 = ~m0;
          p0 = 2'd2; p1 = 2'd1;
          pin = ~inv;
          cyc(4);
          clear_flags();
          cyc(1);
          check("R8 cleared", flag, 0);
          check("R1 state high", 32'(st[i]), (m < 4) ? 1 : 0);
          check("R2 others zero", 32'(st & ~m0), 0);

          // falling of the inverted value (R5 when v=1)
          pin[i] = inv[i];
          #1;
          check("R10 wake fall", 32'(wake), (m == 0 || m == 3 || (m == 2 && i == 2)) ? 1 : 0);
          check("R6 low event comb", 32'(ev[i]), (m == 3) ? 1 : 0);
          cyc(2);
          check("R1 state low", 32'(st[i]), 0);
          check("R6 event fall", 32'(ev[i]), (m == 0 || m == 2 || m == 3) ? 1 : 0);
          cyc(1);
          check("R3 flag fall", 32'(flag[0]), (m == 0 || m == 2 || m == 3) ? 1 : 0);
          check("R7 flag1 unmasked", 32'(flag[1]), 0);
          check("R9 irq0", 32'(irq[0]), 32'(flag[0]));
          check("R9 prio0", 32'(ip0), flag[0] ? 2 : 0);
          clear_flags();
          cyc(1);
          check("R4 low re-set", 32'(flag[0]), (m == 3) ? 1 : 0);

          // rising of the inverted value
          pin[i] = ~inv[i];
          #1;
          check("R10 wake rise", 32'(wake), (m == 0 || (m == 1 && i == 2)) ? 1 : 0);
          cyc(2);
          check("R1 state back", 32'(st[i]), (m < 4) ? 1 : 0);
          check("R6 event rise", 32'(ev[i]), (m == 0 || m == 1) ? 1 : 0);
          cyc(1);
          check("R3 flag rise", 32'(flag[0]), (m == 0 || m == 1 || m == 3) ? 1 : 0);
          check("R2 disabled no flag", 32'(flag), 0 + ((m == 0 || m == 1 || m == 3) ? 1 : 0));
        end
      end
    end

    // R9 and R10: priority zero gates irq and wake, flag still sets.
    mode = {NPIN{3'd4}}; mode[3*5 +: 3] = 3'd0;
    inv = '0; m0 = 8'h20; m1 = '0; p0 = 2'd0; p1 = 2'd3; pin = '0;
    cyc(4); clear_flags(); cyc(1);
    pin[5] = 1'b1;
    #1;
    check("R10 wake prio zero", 32'(wake), 0);
    cyc(3);
    check("R9 flag without prio", 32'(flag[0]), 1);
    check("R9 irq gated", 32'(irq[0]), 0);
    check("R9 prio out gated", 32'(ip0), 0);

    // R7: mask1 route only.
    mode = {NPIN{3'd4}}; mode[3*6 +: 3] = 3'd1;
    m0 = '0; m1 = 8'h40; p0 = 2'd1; p1 = 2'd3; pin = '0;
    cyc(4); clear_flags(); cyc(1);
    pin[6] = 1'b1;
    cyc(3);
    check("R7 flag1 set", 32'(flag), 2);
    check("R9 prio1 out", 32'(ip1), 3);
    check("R10 wake rise pin6", 32'(wake), 0);

    // R8: clear while a new edge arrives on the same clock edge.
    pin[6] = 1'b0; cyc(4);
    pin[6] = 1'b1; cyc(2);
    clr = 2'b10; cyc(1); clr = 2'b00;
    check("R8 set wins", 32'(flag[1]), 1);
    clear_flags(); cyc(1);
    check("R8 clear", 32'(flag[1]), 0);

    // R11: sub-cycle low glitch in low-level mode.
    mode = {NPIN{3'd4}}; mode[3*3 +: 3] = 3'd3;
    m0 = 8'h08; m1 = '0; p0 = 2'd1; pin = 8'hFF; inv = '0;
    cyc(4); clear_flags(); cyc(1);
    check("R11 flag idle", 32'(flag[0]), 0);
    #1 pin[3] = 1'b0;
    #1 check("R11 wake on glitch", 32'(wake), 1);
    #1 pin[3] = 1'b1;
    cyc(4);
    check("R11 no flag", 32'(flag[0]), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule